// File: doc/BRIEF.md
# Page-Mode DRAM Block Read Controller

This controller serves cache-line fills from an asynchronous DRAM whose row and column addresses share one multiplexed bus. A requester presents a block address. When the controller accepts it, the controller opens the addressed row with the row strobe and keeps that row open for the whole transfer. It then steps through four consecutive columns with the column strobe and samples one 64-bit beat from the data pins for each column. After the last beat it returns the assembled 32-byte block together with a single-cycle done pulse.

A mode input picks the beat cadence for each request. The slower fast-page cadence takes 5-3-3-3 cycles. The faster extended-data-out cadence takes 5-2-2-2 cycles and presents the next column while the device still holds the previous data.

Between transfers the controller runs row-only refresh cycles. These are paced by an internal interval counter and walk through the rows in sequence. A refresh that falls due during a transfer waits until the transfer has finished. A pending refresh takes priority over new requests.

Top module: `dram_burst_rd`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ras_n`, `cas_n` and `oe_n` are high, `dram_addr` is 0, `done` is 0 and `ready` is 1.
- R2: A request is accepted at a clock edge where `req` and `ready` are both high. In the first cycle after acceptance, `ras_n` goes low and `dram_addr` carries the row, which is `blk_addr[25:12]`. `oe_n` is low in every cycle of the transfer.
- R3: In the second transfer cycle `dram_addr` carries the first column and `cas_n` is still high. `cas_n` is never low while `ras_n` is high, and the column address does not change while `cas_n` stays low.
- R4: Beat i (i = 0..3) uses column `{blk_addr[11:0], 2'b00} + i`. `ras_n` stays low from the first transfer cycle to the last.
- R5: With `mode`=0 the beats last 5, 3, 3 and 3 cycles, 14 in total. In beat 0 `cas_n` is low in its last three cycles. In each later beat `cas_n` is high in the first cycle, which presents the new column, and low in the other two.
- R6: With `mode`=1 the beats last 5, 2, 2 and 2 cycles, 11 in total. Each later beat is one high cycle followed by one low cycle of `cas_n`. The mode is sampled at acceptance, and later changes on `mode` do not affect a transfer in progress.
- R7: Each beat is sampled from `dq_in` at the clock edge that ends the beat's last cycle. Beat i appears at `block[64*i+63:64*i]`.
- R8: `done` is high for exactly one cycle, the cycle right after the last beat. In that cycle `ras_n`, `cas_n` and `oe_n` are all high and `block` holds the four beats.
- R9: `ready` goes low from the cycle after acceptance until the done cycle. A `req` seen while `ready` is low is ignored.
- R10: A refresh falls due at every `REF_INTERVAL`-th clock edge after reset. It stays pending until it is serviced.
- R11: A refresh holds `ras_n` low for `REF_LEN` cycles while `cas_n` and `oe_n` stay high. It drives the refresh row on `dram_addr`. The refresh row starts at 0 and advances by one, modulo 2^14, after each refresh.
- R12: A pending refresh starts only from an idle or done cycle, never inside a transfer, and it wins over a simultaneous request. `ready` is low while a refresh is pending or running. At least one idle cycle, with all strobes high, follows each refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Block read request |
| mode | input | 1 | Beat cadence: 0 = 5-3-3-3, 1 = 5-2-2-2 |
| blk_addr | input | 26 | Block address: row in [25:12], block index within row in [11:0] |
| ready | output | 1 | Controller can accept a request this cycle |
| done | output | 1 | One-cycle pulse, block valid |
| block | output | 256 | Assembled block, beat 0 in the low bits |
| dram_addr | output | 14 | Multiplexed row/column address bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | Device output enable, active low |
| dq_in | input | 64 | Data pins from the device |

## Verification
Every strobe and address output changes on the edge that starts its cycle. The first transfer cycle therefore follows the acceptance edge directly, and `done` appears 14 edges (mode 0) or 11 edges (mode 1) after acceptance. A refresh begins on the edge after a due refresh meets an idle or done cycle. The reference model advances its state on the same rising edges as the design and compares every output at the following falling edge, so each expected value is read one half-period after it should have settled. The block is compared only in the cycle where the model expects the done pulse.

// File: rtl/drb_pkg.sv
package drb_pkg;

   // controller phase as seen by every sub-unit
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_BURST = 2'd1,
      PH_DONE  = 2'd2,
      PH_REF   = 2'd3
   } drb_phase_e;

   function automatic int drb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/drb_refresh_timer.sv
module drb_refresh_timer #(
   parameter int INTERVAL = 1560,
   parameter int ROW_W    = 14,
   localparam int CNT_W   = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             finish,
   output logic             pend,
   output logic [ROW_W-1:0] row
);

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   if (INTERVAL < 2) begin : g_bad_interval
      $error("refresh interval must be at least 2");
   end

   // a power-of-two interval wraps on the all-ones count, others compare
   if ((INTERVAL & (INTERVAL - 1)) == 0) begin : g_pow2
      assign wrap = &cnt;
   end else begin : g_cmp
      assign wrap = (cnt == CNT_W'(INTERVAL - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (wrap) begin
         cnt  <= '0;
         pend <= 1'b1;
      end else begin
         cnt <= cnt + CNT_W'(1);
         if (take) pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row <= '0;
      else if (finish) row <= row + ROW_W'(1);
   end

endmodule

// File: rtl/drb_sequencer.sv
module drb_sequencer
   import drb_pkg::*;
#(
   parameter int BEATS     = 4,
   parameter int FIRST_LEN = 5,
   parameter int FPM_LEN   = 3,
   parameter int EDO_LEN   = 2,
   parameter int REF_LEN   = 4,
   parameter int COL_SETUP = 2,
   localparam int BEAT_W   = $clog2(BEATS),
   localparam int MAXLEN   = drb_max(drb_max(FIRST_LEN, FPM_LEN), REF_LEN),
   localparam int POS_W    = $clog2(MAXLEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              mode,
   input  logic              ref_pend,
   output drb_phase_e        phase,
   output logic [BEAT_W-1:0] beat,
   output logic              accept,
   output logic              take,
   output logic              ref_fin,
   output logic              cap_en,
   output logic              row_sel,
   output logic              ras_n,
   output logic              cas_n,
   output logic              oe_n,
   output logic              ready,
   output logic              done
);

   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] beat_len;
   logic             edo_q;
   logic             idle_like;
   logic             in_burst;
   logic             last_pos;
   logic             last_beat;
   logic             ref_last;
   logic             col_low;

   if (FIRST_LEN <= COL_SETUP) begin : g_bad_first
      $error("first beat must be longer than the column setup");
   end
   if (EDO_LEN < 2 || FPM_LEN <= EDO_LEN) begin : g_bad_cadence
      $error("cadences need EDO_LEN >= 2 and FPM_LEN > EDO_LEN");
   end
   if (REF_LEN < 1) begin : g_bad_ref
      $error("refresh length must be at least one cycle");
   end

   always_comb begin
      if (beat == '0)  beat_len = POS_W'(FIRST_LEN);
      else if (edo_q)  beat_len = POS_W'(EDO_LEN);
      else             beat_len = POS_W'(FPM_LEN);
   end

   assign idle_like = (phase == PH_IDLE) || (phase == PH_DONE);
   assign in_burst  = (phase == PH_BURST);
   assign last_pos  = (pos == beat_len - POS_W'(1));
   assign last_beat = (beat == BEAT_W'(BEATS - 1));
   assign ref_last  = (pos == POS_W'(REF_LEN - 1));

   assign ready  = idle_like && !ref_pend;
   assign take   = idle_like && ref_pend;
   assign accept = ready && req;

   // first beat waits for the column setup, later beats open one cycle in
   assign col_low = (beat == '0) ? (pos >= POS_W'(COL_SETUP)) : (pos != '0);

   assign ras_n   = !(in_burst || (phase == PH_REF));
   assign oe_n    = !in_burst;
   assign cas_n   = !(in_burst && col_low);
   assign row_sel = in_burst && (beat == '0) && (pos == '0);
   assign cap_en  = in_burst && last_pos;
   assign ref_fin = (phase == PH_REF) && ref_last;
   assign done    = (phase == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         beat  <= '0;
         pos   <= '0;
         edo_q <= 1'b0;
      end else begin
         unique case (phase)
            PH_BURST: begin
               if (last_pos) begin
                  pos <= '0;
                  if (last_beat) begin
                     phase <= PH_DONE;
                     beat  <= '0;
                  end else begin
                     beat <= beat + BEAT_W'(1);
                  end
               end else begin
                  pos <= pos + POS_W'(1);
               end
            end
            PH_REF: begin
               if (ref_last) begin
                  phase <= PH_IDLE;
                  pos   <= '0;
               end else begin
                  pos <= pos + POS_W'(1);
               end
            end
            default: begin
               if (take) begin
                  phase <= PH_REF;
                  pos   <= '0;
               end else if (accept) begin
                  phase <= PH_BURST;
                  beat  <= '0;
                  pos   <= '0;
                  edo_q <= mode;
               end else begin
                  phase <= PH_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/drb_addr_unit.sv
module drb_addr_unit
   import drb_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS),
   localparam int BLK_W  = 2 * ADDR_W - BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [BLK_W-1:0]  blk_addr,
   input  drb_phase_e        phase,
   input  logic [BEAT_W-1:0] beat,
   input  logic              row_sel,
   input  logic [ADDR_W-1:0] ref_row,
   output logic [ADDR_W-1:0] dram_addr
);

   logic [ADDR_W-1:0] row_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q  <= '0;
         base_q <= '0;
      end else if (accept) begin
         row_q  <= blk_addr[BLK_W-1 -: ADDR_W];
         base_q <= {blk_addr[ADDR_W-BEAT_W-1:0], {BEAT_W{1'b0}}};
      end
   end

   // base is block aligned, so or-ing the beat index equals adding it
   assign col = base_q | ADDR_W'(beat);

   always_comb begin
      unique case (phase)
         PH_BURST: dram_addr = row_sel ? row_q : col;
         PH_REF:   dram_addr = ref_row;
         default:  dram_addr = '0;
      endcase
   end

endmodule

// File: rtl/drb_beat_assembler.sv
module drb_beat_assembler #(
   parameter int DATA_W  = 64,
   parameter int BEATS   = 4,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_en,
   input  logic [BEAT_W-1:0]       beat,
   input  logic [DATA_W-1:0]       dq,
   output logic [BEATS*DATA_W-1:0] block
);

   for (genvar g = 0; g < BEATS; g++) begin : g_slot
      logic [DATA_W-1:0] slot_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    slot_q <= '0;
         else if (cap_en && (beat == BEAT_W'(g)))       slot_q <= dq;
      end

      assign block[g*DATA_W +: DATA_W] = slot_q;
   end

endmodule

// File: rtl/dram_burst_rd.sv
module dram_burst_rd
   import drb_pkg::*;
#(
   parameter int ADDR_W       = 14,
   parameter int DATA_W       = 64,
   parameter int BLOCK_BYTES  = 32,
   parameter int FIRST_LEN    = 5,
   parameter int FPM_LEN      = 3,
   parameter int EDO_LEN      = 2,
   parameter int REF_INTERVAL = 1560,
   parameter int REF_LEN      = 4,
   localparam int BLOCK_W     = BLOCK_BYTES * 8,
   localparam int BEATS       = BLOCK_W / DATA_W,
   localparam int BEAT_W      = $clog2(BEATS),
   localparam int BLK_W       = 2 * ADDR_W - BEAT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic               mode,
   input  logic [BLK_W-1:0]   blk_addr,
   output logic               ready,
   output logic               done,
   output logic [BLOCK_W-1:0] block,
   output logic [ADDR_W-1:0]  dram_addr,
   output logic               ras_n,
   output logic               cas_n,
   output logic               oe_n,
   input  logic [DATA_W-1:0]  dq_in
);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0 || BEATS * DATA_W != BLOCK_W) begin : g_bad_geom
      $error("block must hold a power-of-two count of at least two beats");
   end

   drb_phase_e        phase;
   logic [BEAT_W-1:0] beat;
   logic              accept;
   logic              take;
   logic              ref_fin;
   logic              cap_en;
   logic              row_sel;
   logic              ref_pend;
   logic [ADDR_W-1:0] ref_row;

   drb_refresh_timer #(
      .INTERVAL (REF_INTERVAL),
      .ROW_W    (ADDR_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .finish (ref_fin),
      .pend   (ref_pend),
      .row    (ref_row)
   );

   drb_sequencer #(
      .BEATS     (BEATS),
      .FIRST_LEN (FIRST_LEN),
      .FPM_LEN   (FPM_LEN),
      .EDO_LEN   (EDO_LEN),
      .REF_LEN   (REF_LEN),
      .COL_SETUP (2)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .mode     (mode),
      .ref_pend (ref_pend),
      .phase    (phase),
      .beat     (beat),
      .accept   (accept),
      .take     (take),
      .ref_fin  (ref_fin),
      .cap_en   (cap_en),
      .row_sel  (row_sel),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .oe_n     (oe_n),
      .ready    (ready),
      .done     (done)
   );

   drb_addr_unit #(
      .ADDR_W (ADDR_W),
      .BEATS  (BEATS)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .blk_addr  (blk_addr),
      .phase     (phase),
      .beat      (beat),
      .row_sel   (row_sel),
      .ref_row   (ref_row),
      .dram_addr (dram_addr)
   );

   drb_beat_assembler #(
      .DATA_W (DATA_W),
      .BEATS  (BEATS)
   ) u_asm (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (cap_en),
      .beat   (beat),
      .dq     (dq_in),
      .block  (block)
   );

endmodule

// File: rtl/drb_checker.sv
module drb_checker #(
   parameter int BEATS  = 4,
   parameter int ADDR_W = 14,
   localparam int CNT_W = $clog2(BEATS + 1) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              ready,
   input logic              done,
   input logic              ras_n,
   input logic              cas_n,
   input logic              oe_n,
   input logic [ADDR_W-1:0] dram_addr
);

   logic             cas_q;
   logic [CNT_W-1:0] falls;

   // column strobe falls seen while the row is open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cas_q <= 1'b1;
         falls <= '0;
      end else begin
         cas_q <= cas_n;
         if (ras_n)                falls <= '0;
         else if (!cas_n && cas_q) falls <= falls + CNT_W'(1);
      end
   end

   assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_col_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

   assert_beat_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ras_n) && $past(!oe_n)) |-> (falls == CNT_W'(BEATS)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ras_n && cas_n && oe_n));

   assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   assert_refresh_no_col_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && oe_n) |-> cas_n);

endmodule

bind dram_burst_rd drb_checker #(
   .BEATS  (BEATS),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .ready     (ready),
   .done      (done),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .oe_n      (oe_n),
   .dram_addr (dram_addr)
);

// File: tb/dram_burst_rd_test.sv
`timescale 1ns/1ps
module dram_burst_rd_test;

   localparam int REF_INT = 97;
   localparam int REF_LEN = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic         mode = 1'b0;
   logic [25:0]  blk_addr = '0;
   logic         ready, done, ras_n, cas_n, oe_n;
   logic [255:0] block;
   logic [13:0]  dram_addr;
   logic [63:0]  dq_in;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dram_burst_rd #(
      .REF_INTERVAL (REF_INT),
      .REF_LEN      (REF_LEN)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .mode      (mode),
      .blk_addr  (blk_addr),
      .ready     (ready),
      .done      (done),
      .block     (block),
      .dram_addr (dram_addr),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .oe_n      (oe_n),
      .dq_in     (dq_in)
   );

   function automatic logic [63:0] pat(input logic [13:0] r, input logic [13:0] c);
      return {2'b00, r, 2'b00, c, 2'b10, r ^ 14'h2AAA, 2'b01, c ^ 14'h1555};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int           m_ph, m_c, m_cnt, m_nacc;
   logic         m_mode, m_pend;
   logic [13:0]  m_row, m_base, m_rrow;
   logic [255:0] m_blk;
   bit           mi_idle, mi_take, mi_acc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_c <= 0; m_cnt <= 0; m_nacc <= 0;
         m_mode <= 0; m_pend <= 0; m_row <= '0; m_base <= '0; m_rrow <= '0; m_blk <= '0;
      end else begin
         mi_idle = (m_ph == 0) || (m_ph == 2);
         mi_take = mi_idle && m_pend;
         mi_acc  = mi_idle && !m_pend && req;
         if (m_cnt == REF_INT - 1) begin
            m_cnt <= 0; m_pend <= 1;
         end else begin
            m_cnt <= m_cnt + 1;
            if (mi_take) m_pend <= 0;
         end
         if (mi_take) begin
            m_ph <= 3; m_c <= 0;
         end else if (mi_acc) begin
            m_ph <= 1; m_c <= 0; m_mode <= mode; m_nacc <= m_nacc + 1;
            m_row  <= blk_addr[25:12];
            m_base <= {blk_addr[11:0], 2'b00};
            for (int i = 0; i < 4; i++)
               m_blk[64*i +: 64] <= pat(blk_addr[25:12], {blk_addr[11:0], 2'b00} + 14'(i));
         end else begin
            case (m_ph)
               2: m_ph <= 0;
               1: if (m_c == (m_mode ? 10 : 13)) m_ph <= 2; else m_c <= m_c + 1;
               3: if (m_c == REF_LEN - 1) begin m_ph <= 0; m_rrow <= m_rrow + 14'd1; end
                  else m_c <= m_c + 1;
               default: ;
            endcase
         end
      end
   end

   // ---------------- behavioural DRAM ----------------
   logic [13:0] d_row, d_col;
   logic        d_col_ok = 0, d_ras_q = 1, d_cas_q = 1;

   always @(negedge clk) begin
      if (!ras_n && d_ras_q) d_row <= dram_addr;
      if (ras_n) d_col_ok <= 0;
      else if (!cas_n && d_cas_q) begin
         d_col <= dram_addr; d_col_ok <= 1;
      end
      if (!cas_n && d_cas_q && rst_n) chk(!ras_n, "R3 cas fall with row open", 64'(ras_n), 64'(0));
      d_ras_q <= ras_n;
      d_cas_q <= cas_n;
   end

   // fast-page device drives data only while CAS is low; EDO keeps it
   assign dq_in = (!oe_n && d_col_ok && (!cas_n || m_mode)) ? pat(d_row, d_col) : 64'd0;

   // ---------------- comparison every cycle ----------------
   logic        e_ras, e_cas, e_oe, e_ready, e_done;
   logic [13:0] e_addr;
   int          k, bl, bp;
   string       t_ras, t_cas, t_addr, t_rdy;

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(ras_n && cas_n && oe_n, "R1 strobes in reset", 64'({ras_n, cas_n, oe_n}), 64'(7));
         chk(dram_addr == 14'd0, "R1 addr in reset", 64'(dram_addr), 64'(0));
         chk(ready && !done, "R1 ready/done in reset", 64'({ready, done}), 64'(2));
      end else begin
         e_ras = 1; e_cas = 1; e_oe = 1; e_addr = '0;
         t_ras = "R12 idle ras"; t_cas = "R12 idle cas"; t_addr = "R12 idle addr";
         case (m_ph)
            1: begin
               e_ras = 0; e_oe = 0; t_ras = "R4 row held";
               t_cas = m_mode ? "R6 edo cadence" : "R5 fpm cadence";
               if (m_c < 5) begin
                  e_cas  = (m_c >= 2) ? 1'b0 : 1'b1;
                  e_addr = (m_c == 0) ? m_row : m_base;
                  t_addr = (m_c == 0) ? "R2 row addr" : "R3 first col";
                  if (m_c == 0) t_ras = "R2 ras fall";
               end else begin
                  bl = m_mode ? 2 : 3;
                  k  = m_c - 5;
                  bp = k % bl;
                  e_cas  = (bp == 0);
                  e_addr = m_base + 14'(1 + k / bl);
                  t_addr = "R4 col step";
               end
            end
            3: begin
               e_ras = 0; e_addr = m_rrow;
               t_ras = (m_c == 0) ? "R10 refresh due" : "R11 refresh ras";
               t_cas = "R11 refresh cas"; t_addr = "R11 refresh row";
            end
            default: ;
         endcase
         e_ready = ((m_ph == 0) || (m_ph == 2)) && !m_pend;
         e_done  = (m_ph == 2);
         t_rdy   = m_pend ? "R12 ready held by refresh" : "R9 ready";
         chk(ras_n == e_ras, t_ras, 64'(ras_n), 64'(e_ras));
         chk(cas_n == e_cas, t_cas, 64'(cas_n), 64'(e_cas));
         chk(oe_n == e_oe, "R2 oe", 64'(oe_n), 64'(e_oe));
         chk(dram_addr == e_addr, t_addr, 64'(dram_addr), 64'(e_addr));
         chk(ready == e_ready, t_rdy, 64'(ready), 64'(e_ready));
         chk(done == e_done, "R8 done pulse", 64'(done), 64'(e_done));
         if (e_done)
            for (int i = 0; i < 4; i++)
               chk(block[64*i +: 64] == m_blk[64*i +: 64], "R7 block beat",
                   block[64*i +: 64], m_blk[64*i +: 64]);
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] lf = 32'h1D2C_3B4A;

   task automatic step_lfsr();
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
   endtask

   task automatic send(input logic [25:0] a, input logic md);
      int start;
      @(negedge clk);
      req = 1; blk_addr = a; mode = md; start = m_nacc;
      while (m_nacc == start) @(negedge clk);
      // R6/R9: disturb inputs during the transfer; they must be ignored
      req = 1; mode = ~md; blk_addr = ~a;
      @(negedge clk);
      req = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      send(26'h0123456, 1'b0);
      repeat (20) @(negedge clk);
      send(26'h2ABCDEF, 1'b1);
      repeat (20) @(negedge clk);
      send(26'h3FFFFFF, 1'b0);
      send(26'h0000000, 1'b1);
      send(26'h3FFFFFF, 1'b1);
      repeat (220) @(negedge clk);
      for (int n = 0; n < 60; n++) begin
         step_lfsr();
         send(lf[25:0], lf[27]);
         repeat (int'(lf[30:28])) @(negedge clk);
      end
      repeat (30) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #4000000;
      if (!finished) begin
         finished = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule